// File: doc/BRIEF.md
# Sign-Magnitude Correlation Learning Synapse

One adaptive synapse cell. Many of these are placed in an array between pairs of binary neurons. The cell holds a weight as a sign bit and an unsigned magnitude. During a training presentation it records the product of its two neuron states twice, into two one-bit correlation latches. The first record is taken when the network runs free. The second is taken when the output neurons are clamped to the wanted values. An adjust strobe then moves the weight one step toward the clamped correlation. Nothing happens when the two correlations agree.

A neuron state is one bit: 1 stands for +1 (level above the midpoint) and 0 stands for -1. The product of two states is +1 when the bits are equal and -1 when they differ. The weight stops at the magnitude limit instead of wrapping. An external load replaces the learned weight. The cell drives the weight and two signed products. The forward product is the presynaptic state times the weight and feeds the postsynaptic neuron. The backward product is the postsynaptic state times the weight and feeds the presynaptic neuron. Each direction has its own enable, so the array can build asymmetric networks. Analog multiplication and current summing happen outside this cell.

All pins are plain control and status signals. None of them is a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `corr_synapse`

## Requirements
- R1: After reset the weight is +0 (w_sign=0, w_mag=0) and both correlation latches hold +1, so an adjust strobe issued before any capture leaves the weight at +0.
- R2: On a clock edge with cap_free=1 the free latch takes the product of pre_state and post_state (+1 when the bits are equal, -1 when they differ). cap_clamp does the same for the clamped latch. An adjust strobe on that same edge still uses the values the latches held before the edge.
- R3: On adjust without load, the weight rises by one when the clamped latch is +1 and the free latch is -1. It falls by one when the clamped latch is -1 and the free latch is +1.
- R4: On adjust without load, the weight is unchanged when the two latches hold the same value.
- R5: With MAG_W=4 the weight stays within -15..+15 and saturates at both ends instead of wrapping.
- R6: A negative zero never appears. A step up from -1 gives +0, a step down from +0 gives -1, and a load of sign 1 with magnitude 0 stores +0.
- R7: On a clock edge with load_en=1 the weight becomes {load_sign, load_mag}. This takes priority over an adjust on the same edge.
- R8: When fwd_en=1, fwd_mag equals w_mag and fwd_sign equals w_sign XOR (pre_state==0), with the sign forced to 0 when the magnitude is 0. When fwd_en=0, both outputs are 0. These outputs are combinational.
- R9: bwd_sign and bwd_mag follow the same rule as R8, using post_state and bwd_en.
- R10: On an edge without adjust and without load, the weight holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_state | input | 1 | Presynaptic neuron state (1 = +1, 0 = -1) |
| post_state | input | 1 | Postsynaptic neuron state (1 = +1, 0 = -1) |
| cap_free | input | 1 | Capture the correlation of the free phase |
| cap_clamp | input | 1 | Capture the correlation of the clamped phase |
| adjust | input | 1 | Apply one learning step |
| load_en | input | 1 | Write an external weight |
| load_sign | input | 1 | Sign of the external weight (1 = negative) |
| load_mag | input | MAG_W | Magnitude of the external weight |
| fwd_en | input | 1 | Enable conduction from pre to post |
| bwd_en | input | 1 | Enable conduction from post to pre |
| w_sign | output | 1 | Stored weight sign |
| w_mag | output | MAG_W | Stored weight magnitude |
| fwd_sign | output | 1 | Sign of pre_state times weight |
| fwd_mag | output | MAG_W | Magnitude of the forward product |
| bwd_sign | output | 1 | Sign of post_state times weight |
| bwd_mag | output | MAG_W | Magnitude of the backward product |

## Verification
The bench builds the cell with its default MAG_W=4. With this small limit, runs of steps in one direction reach both saturation points within about fifteen cycles. Random sequences also cross zero in both directions many times. Those random sequences mix loads of negative zero, adjusts issued on the same edge as captures, and load/adjust collisions.

// File: rtl/syn_pkg.sv
package syn_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/syn_phase_latch.sv
module syn_phase_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic state_a,
  input  logic state_b,
  output logic corr_pos
);
  // product of two +/-1 states: positive when the bits agree
  always_ff @(posedge clk) begin
    if (!rst_n)   corr_pos <= 1'b1;
    else if (cap) corr_pos <= ~(state_a ^ state_b);
  end
endmodule

// File: rtl/syn_weight_store.sv
module syn_weight_store
  import syn_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             load_sign,
  input  logic [MAG_W-1:0] load_mag,
  input  step_e            step,
  output logic             w_sign,
  output logic [MAG_W-1:0] w_mag
);
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};
  localparam logic [MAG_W-1:0] MAG_ONE = {{(MAG_W-1){1'b0}}, 1'b1};
  localparam logic [MAG_W-1:0] MAG_ZERO = '0;

  logic             nxt_sign;
  logic [MAG_W-1:0] nxt_mag;

  always_comb begin
    nxt_sign = w_sign;
    nxt_mag  = w_mag;
    if (load_en) begin
      nxt_mag  = load_mag;
      nxt_sign = load_sign && (load_mag != MAG_ZERO);
    end else begin
      unique case (step)
        STEP_UP: begin
          if (!w_sign) begin
            if (w_mag != MAG_MAX) nxt_mag = w_mag + MAG_ONE;
          end else begin
            nxt_mag  = w_mag - MAG_ONE;
            nxt_sign = (w_mag != MAG_ONE);
          end
        end
        STEP_DOWN: begin
          if (w_sign) begin
            if (w_mag != MAG_MAX) nxt_mag = w_mag + MAG_ONE;
          end else if (w_mag == MAG_ZERO) begin
            nxt_mag  = MAG_ONE;
            nxt_sign = 1'b1;
          end else begin
            nxt_mag = w_mag - MAG_ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_sign <= 1'b0;
      w_mag  <= '0;
    end else begin
      w_sign <= nxt_sign;
      w_mag  <= nxt_mag;
    end
  end
endmodule

// File: rtl/syn_signed_gate.sv
module syn_signed_gate #(
  parameter int MAG_W = 4
) (
  input  logic             en,
  input  logic             state,
  input  logic             w_sign,
  input  logic [MAG_W-1:0] w_mag,
  output logic             p_sign,
  output logic [MAG_W-1:0] p_mag
);
  always_comb begin
    p_mag  = en ? w_mag : '0;
    p_sign = en && (p_mag != '0) && (w_sign ^ ~state);
  end
endmodule

// File: rtl/corr_synapse.sv
module corr_synapse
  import syn_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_state,
  input  logic             post_state,
  input  logic             cap_free,
  input  logic             cap_clamp,
  input  logic             adjust,
  input  logic             load_en,
  input  logic             load_sign,
  input  logic [MAG_W-1:0] load_mag,
  input  logic             fwd_en,
  input  logic             bwd_en,
  output logic             w_sign,
  output logic [MAG_W-1:0] w_mag,
  output logic             fwd_sign,
  output logic [MAG_W-1:0] fwd_mag,
  output logic             bwd_sign,
  output logic [MAG_W-1:0] bwd_mag
);
  localparam int NPH = 2;  // 0: free phase, 1: clamped phase
  localparam int NDIR = 2; // 0: forward, 1: backward

  logic [NPH-1:0] cap_vec;
  logic [NPH-1:0] corr_vec;
  logic           free_pos;
  logic           clamp_pos;
  step_e          step;

  assign cap_vec = {cap_clamp, cap_free};

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_phase
      syn_phase_latch u_lat (
        .clk(clk), .rst_n(rst_n), .cap(cap_vec[g]),
        .state_a(pre_state), .state_b(post_state),
        .corr_pos(corr_vec[g])
      );
    end
  endgenerate

  assign free_pos  = corr_vec[0];
  assign clamp_pos = corr_vec[1];

  always_comb begin
    step = STEP_NONE;
    if (adjust && (clamp_pos != free_pos))
      step = clamp_pos ? STEP_UP : STEP_DOWN;
  end

  syn_weight_store #(.MAG_W(MAG_W)) u_wt (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sign(load_sign),
    .load_mag(load_mag), .step(step), .w_sign(w_sign), .w_mag(w_mag)
  );

  logic [NDIR-1:0]       dir_en;
  logic [NDIR-1:0]       dir_state;
  logic [NDIR-1:0]       dir_sign;
  logic [MAG_W-1:0]      dir_mag [NDIR];

  assign dir_en    = {bwd_en, fwd_en};
  assign dir_state = {post_state, pre_state};

  generate
    for (g = 0; g < NDIR; g++) begin : g_dir
      syn_signed_gate #(.MAG_W(MAG_W)) u_gate (
        .en(dir_en[g]), .state(dir_state[g]), .w_sign(w_sign), .w_mag(w_mag),
        .p_sign(dir_sign[g]), .p_mag(dir_mag[g])
      );
    end
  endgenerate

  assign fwd_sign = dir_sign[0];
  assign fwd_mag  = dir_mag[0];
  assign bwd_sign = dir_sign[1];
  assign bwd_mag  = dir_mag[1];
endmodule

// File: rtl/corr_synapse_chk.sv
module corr_synapse_chk #(
  parameter int MAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adjust,
  input logic             load_en,
  input logic             load_sign,
  input logic [MAG_W-1:0] load_mag,
  input logic             fwd_en,
  input logic             free_pos,
  input logic             clamp_pos,
  input logic             w_sign,
  input logic [MAG_W-1:0] w_mag,
  input logic [MAG_W-1:0] fwd_mag
);
  localparam int VMAX = (1 << MAG_W) - 1;

  function automatic int sval(input logic s, input logic [MAG_W-1:0] m);
    return s ? -int'(m) : int'(m);
  endfunction

  int cur;
  assign cur = sval(w_sign, w_mag);

  p_no_negzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_sign && (w_mag == '0)));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (w_mag == $past(load_mag)) &&
                (w_sign == ($past(load_sign) && ($past(load_mag) != '0))));

  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adjust && !load_en && clamp_pos && !free_pos) |=>
      ((cur == $past(cur) + 1) || ($past(cur) == VMAX && cur == VMAX)));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adjust && !load_en && !clamp_pos && free_pos) |=>
      ((cur == $past(cur) - 1) || ($past(cur) == -VMAX && cur == -VMAX)));

  p_equal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adjust && !load_en && (clamp_pos == free_pos)) |=> $stable({w_sign, w_mag}));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adjust && !load_en) |=> $stable({w_sign, w_mag}));

  p_fwd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> (fwd_mag == '0));
endmodule

bind corr_synapse corr_synapse_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adjust(adjust), .load_en(load_en),
  .load_sign(load_sign), .load_mag(load_mag), .fwd_en(fwd_en),
  .free_pos(free_pos), .clamp_pos(clamp_pos),
  .w_sign(w_sign), .w_mag(w_mag), .fwd_mag(fwd_mag)
);

// File: tb/test_corr_synapse.sv
module test_corr_synapse;
  localparam int MAG_W = 4;
  localparam int VMAX = (1 << MAG_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre_state = 1'b0, post_state = 1'b0, cap_free = 1'b0, cap_clamp = 1'b0;
  logic adjust = 1'b0, load_en = 1'b0, load_sign = 1'b0, fwd_en = 1'b0, bwd_en = 1'b0;
  logic [MAG_W-1:0] load_mag = '0;
  logic w_sign, fwd_sign, bwd_sign;
  logic [MAG_W-1:0] w_mag, fwd_mag, bwd_mag;

  always #2 clk = ~clk;

  corr_synapse #(.MAG_W(MAG_W)) i_corr_synapse (.*);

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // bench model
  int  m_w = 0;
  bit  m_free = 1, m_clamp = 1;

  function automatic int gate(input bit en, input bit st, input int w);
    if (!en) return 0;
    return st ? w : -w;
  endfunction

  function automatic int to_int(input logic s, input logic [MAG_W-1:0] m);
    return s ? -int'(m) : int'(m);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check(req, "weight", to_int(w_sign, w_mag), m_w);
    check("R6", "weight sign bit", int'(w_sign), int'(m_w < 0));
    check("R8", "forward product", to_int(fwd_sign, fwd_mag), gate(fwd_en, pre_state, m_w));
    check("R8", "forward sign at zero", int'(fwd_sign && fwd_mag == '0), 0);
    check("R9", "backward product", to_int(bwd_sign, bwd_mag), gate(bwd_en, post_state, m_w));
  endtask

  // drive at falling edge, check the combinational outputs, then advance the model
  task automatic step(input bit pre, input bit post, input bit cf, input bit cc,
                      input bit adj, input bit ld, input bit ls, input int lm,
                      input bit fe, input bit be, input string req);
    int nw;
    @(negedge clk);
    pre_state = pre; post_state = post; cap_free = cf; cap_clamp = cc;
    adjust = adj; load_en = ld; load_sign = ls; load_mag = MAG_W'(lm);
    fwd_en = fe; bwd_en = be;
    #1;
    check_outputs(req);
    @(posedge clk);
    nw = m_w;
    if (ld) nw = ls ? -lm : lm;
    else if (adj && m_clamp && !m_free) nw = (m_w < VMAX) ? m_w + 1 : m_w;
    else if (adj && !m_clamp && m_free) nw = (m_w > -VMAX) ? m_w - 1 : m_w;
    if (cf) m_free = (pre == post);
    if (cc) m_clamp = (pre == post);
    m_w = nw;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, adjust before any capture changes nothing
    step(1, 1, 0, 0, 1, 0, 0, 0, 1, 1, "R1");
    step(1, 0, 0, 0, 1, 0, 0, 0, 1, 1, "R1");
    check_outputs("R1");
    // R2/R3: free=-1, clamp=+1, then climb to saturation (R5)
    step(1, 0, 1, 0, 0, 0, 0, 0, 1, 1, "R2");
    step(0, 0, 0, 1, 0, 0, 0, 0, 1, 1, "R2");
    for (int i = 0; i < VMAX + 3; i++) step(1, 1, 0, 0, 1, 0, 0, 0, 1, 1, "R3");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R5");
    check("R5", "positive saturation", to_int(w_sign, w_mag), VMAX);
    // reverse correlations: descend through zero to negative saturation (R6, R5)
    step(0, 0, 1, 1, 0, 0, 0, 0, 1, 1, "R2");
    step(1, 0, 0, 1, 1, 0, 0, 0, 1, 1, "R4");
    for (int i = 0; i < 2 * VMAX + 3; i++) step(0, 1, 0, 0, 1, 0, 0, 0, 0, 1, "R3");
    step(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
    check("R5", "negative saturation", to_int(w_sign, w_mag), -VMAX);
    // R7: load wins over adjust; R6: negative zero load becomes +0
    step(1, 1, 0, 0, 1, 1, 0, 7, 1, 1, "R7");
    step(1, 1, 0, 0, 1, 1, 1, 0, 1, 1, "R7");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R6");
    check("R6", "no negative zero after load", int'(w_sign), 0);
    // R10: idle cycles hold the weight
    step(1, 0, 0, 0, 0, 1, 1, 4, 1, 1, "R7");
    for (int i = 0; i < 3; i++) step(i[0], 1, 0, 0, 0, 0, 0, 0, 1, 1, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step($urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1), r < 6, $urandom_range(0, 1),
           $urandom_range(0, VMAX), $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0, "R3");
    end
    check_outputs("R10");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule